// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that hangs off the system clock and gives a bus master access to a 256-entry, byte-wide register file. The SCL and SDA pins are sampled through synchronisers. The block finds START, repeated START and STOP conditions and moves through the address, write and read phases of a transfer. It drives the bus only through an enable that pulls SDA low. An open-drain pad outside the block turns that enable into the real pin.

A master selects the target with a 7-bit address. After a write-direction address, the first byte sets an internal register pointer. Every byte that follows is stored at the pointer, and the pointer then steps forward. After a read-direction address, the target sends the byte at the pointer and steps forward. It keeps sending as long as the master acknowledges. On-chip logic can read any entry at any time through a separate combinational read port. Clock stretching is not supported, and only 7-bit addresses are decoded.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, `sda_pull` is 0. Every register reads 0x00, except the entries in the reset-value list, which by default are 0x3A = 0x16 and 0x0E = 0x80.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The first byte after a START is sent MSB first. It carries the target address in bits 7:1 and the direction in bit 0, with 1 for read and 0 for write.
- R3: The target pulls SDA low in the ninth clock of the address byte only when bits 7:1 equal `DEV_ADDR` (0x2A by default). On a mismatch it never pulls SDA low and changes no register until the next START.
- R4: In a write transfer, every byte after the address is acknowledged. The first such byte loads the register pointer, and each later byte is stored at the pointer.
- R5: The pointer increments by one after each data byte written or read, and wraps from 0xFF to 0x00.
- R6: In a read transfer, the target sends the byte at the pointer MSB first and changes SDA only while SCL is low. It sends the next byte after a master acknowledge (SDA low in the ninth clock). After a master not-acknowledge it leaves SDA released.
- R7: A STOP at any point, including in the middle of a byte, discards the partial byte, releases SDA and returns the target to idle listening.
- R8: A repeated START without a STOP before it begins a new address phase. The register pointer keeps its value across any START.
- R9: The acknowledge of a written byte is released within 4 system clocks after the falling SCL edge that ends the ninth clock.
- R10: `rd_data` shows the register at `rd_addr` combinationally, including writes made over the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL high and low phases must each last several cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level (wired-AND bus value) |
| rd_addr | input | 8 | Local read port address |
| sda_pull | output | 1 | 1 = pull SDA low |
| rd_data | output | 8 | Local read port data |

## Verification
A wrong phase or bit count appears at the ports in the ninth clock of the byte where it happens. The master then sees a missing acknowledge or one that should not be there, or read data shifted by one bit. A pointer that is stale or steps wrongly cannot be seen on the bus. It shows only later, as data landing in the wrong entry of the local read port, or as the wrong byte after a repeated START. For that reason the bench reads back through both paths. A STOP or START that is missed leaves the target in a data phase, so the very next address byte gets no acknowledge or gets a wrong one.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int BITCNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic rst_s_n,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] rst_ff;
  logic       scl_m, sda_m, scl_p, sda_p;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_s_n = rst_ff[1];

  // two-flop synchronisers plus one history stage; idle bus is high
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int PTR_W = 8,
  parameter int INIT_N = 2,
  parameter logic [INIT_N*16-1:0] INIT_LIST = {16'h3A16, 16'h0E80}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [PTR_W-1:0] bus_addr,
  output logic [7:0]       bus_data,
  input  logic [PTR_W-1:0] loc_addr,
  output logic [7:0]       loc_data
);
  localparam int DEPTH = 1 << PTR_W;

  logic [7:0] mem [DEPTH];

  function automatic logic [7:0] reset_val(input int idx);
    logic [7:0] v;
    v = 8'h00;
    for (int k = 0; k < INIT_N; k++) begin
      if (int'(INIT_LIST[k*16+8 +: 8]) == idx) v = INIT_LIST[k*16 +: 8];
    end
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= reset_val(i);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign bus_data = mem[bus_addr];
  assign loc_data = mem[loc_addr];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_byte,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);
  localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);

  tgt_state_t           state_q, state_d;
  logic [BITCNT_W-1:0]  bit_q, bit_d;
  logic [7:0]           shr_q, shr_d;
  logic [PTR_W-1:0]     ptr_q, ptr_d;
  logic                 pfirst_q, pfirst_d;
  logic                 rw_q, rw_d;
  logic                 mack_q, mack_d;
  logic                 pull_q, pull_d;

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    shr_d    = shr_q;
    ptr_d    = ptr_q;
    pfirst_d = pfirst_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    pull_d   = pull_q;
    wr_en    = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
      bit_d   = '0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      pull_d  = 1'b0;
      bit_d   = '0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise && bit_q != FULL) begin
            shr_d = {shr_q[6:0], sda_s};
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && bit_q == FULL) begin
            if (shr_q[7:1] == DEV_ADDR) begin
              rw_d    = shr_q[0];
              pull_d  = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rw_q) begin
              shr_d   = rd_byte;
              pull_d  = ~rd_byte[7];
              state_d = ST_RD;
            end else begin
              pull_d   = 1'b0;
              pfirst_d = 1'b1;
              state_d  = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise && bit_q != FULL) begin
            shr_d = {shr_q[6:0], sda_s};
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && bit_q == FULL) begin
            pull_d  = 1'b1;
            state_d = ST_WR_ACK;
            if (pfirst_q) begin
              ptr_d    = shr_q[PTR_W-1:0];
              pfirst_d = 1'b0;
            end else begin
              wr_en = 1'b1;
              ptr_d = ptr_q + 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            bit_d   = '0;
            state_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_d = bit_q + 1'b1;
          end else if (scl_fall) begin
            if (bit_q == FULL) begin
              pull_d  = 1'b0;
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RD_ACK;
            end else begin
              shr_d  = {shr_q[6:0], 1'b0};
              pull_d = ~shr_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            bit_d = '0;
            if (mack_q) begin
              shr_d   = rd_byte;
              pull_d  = ~rd_byte[7];
              state_d = ST_RD;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          pull_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      shr_q    <= '0;
      ptr_q    <= '0;
      pfirst_q <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      pull_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bit_q    <= bit_d;
      shr_q    <= shr_d;
      ptr_q    <= ptr_d;
      pfirst_q <= pfirst_d;
      rw_q     <= rw_d;
      mack_q   <= mack_d;
      pull_q   <= pull_d;
    end
  end

  assign ptr      = ptr_q;
  assign wr_data  = shr_q;
  assign sda_pull = pull_q;
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int PTR_W = 8,
  parameter int INIT_N = 2,
  parameter logic [INIT_N*16-1:0] INIT_LIST = {16'h3A16, 16'h0E80}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [PTR_W-1:0] rd_addr,
  output logic             sda_pull,
  output logic [7:0]       rd_data
);
  logic             rst_s_n, scl_s, sda_s;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] ptr;
  logic             wr_en;
  logic [7:0]       wr_data, bus_rd;

  i2c_tgt_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .rst_s_n(rst_s_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_byte(bus_rd), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .sda_pull(sda_pull)
  );

  i2c_tgt_regs #(.PTR_W(PTR_W), .INIT_N(INIT_N), .INIT_LIST(INIT_LIST)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_addr(ptr),
    .wr_data(wr_data), .bus_addr(ptr), .bus_data(bus_rd),
    .loc_addr(rd_addr), .loc_data(rd_data)
  );
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_pull,
  input logic             wr_en,
  input logic [PTR_W-1:0] ptr
);
  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  assert_start_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);

  assert_sda_change_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == $past(ptr) + 1'b1);

  assert_write_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_s);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_pull(sda_pull), .wr_en(wr_en), .ptr(ptr)
);

// File: tb/i2c_regfile_target_test.sv
`timescale 1ns/1ps
module i2c_regfile_target_test;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'h54;  // 0x2A, write
  localparam logic [7:0] AR = 8'h55;  // 0x2A, read

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [7:0] rd_addr = 8'h00;
  logic sda_pull;
  logic [7:0] rd_data;
  wire sda_line = m_sda & ~sda_pull;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit rel_ok;

  always #2.5 clk = ~clk;

  i2c_regfile_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .rd_addr(rd_addr), .sda_pull(sda_pull), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q/2); b = sda_line;
    wt(Q/2); m_scl = 1'b0; wt(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q/2); ack = ~sda_line;
    wt(Q/2); m_scl = 1'b0; wt(4); rel_ok = (sda_pull == 1'b0); wt(Q-4);
  endtask

  task automatic get_byte(output logic [7:0] v, input bit nack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(nack);
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string req);
    rd_addr = a; #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
    peek(8'h3A, 8'h16, "R1 init 3A");
    peek(8'h0E, 8'h80, "R1 init 0E");
    peek(8'h00, 8'h00, "R1 zero 00");
    peek(8'hFF, 8'h00, "R10 zero FF");
  endtask

  task automatic t_wrong_addr();
    bit a;
    bus_start();
    put_byte(8'h32, a); chk(!a, "R3 mismatch no ack", a, 0);
    put_byte(8'h10, a); chk(!a, "R3 silent after mismatch", a, 0);
    put_byte(8'h99, a); chk(!a, "R3 silent data", a, 0);
    bus_stop();
    peek(8'h10, 8'h00, "R3 no register change");
  endtask

  task automatic t_write();
    bit a;
    bus_start();
    put_byte(AW, a); chk(a, "R2 address ack", a, 1);
    put_byte(8'h10, a); chk(a, "R4 pointer ack", a, 1);
    put_byte(8'hA5, a); chk(a, "R4 data ack", a, 1);
    chk(rel_ok, "R9 ack released", rel_ok, 1);
    put_byte(8'h5C, a); chk(a, "R4 data ack 2", a, 1);
    put_byte(8'h77, a); put_byte(8'h3C, a);
    bus_stop();
    peek(8'h10, 8'hA5, "R4 stored 10");
    peek(8'h11, 8'h5C, "R5 stored 11");
    peek(8'h13, 8'h3C, "R10 stored 13");
  endtask

  task automatic t_wrap();
    bit a;
    bus_start();
    put_byte(AW, a); put_byte(8'hFF, a);
    put_byte(8'h11, a); put_byte(8'h22, a); chk(a, "R5 ack after wrap", a, 1);
    bus_stop();
    peek(8'hFF, 8'h11, "R5 entry FF");
    peek(8'h00, 8'h22, "R5 wrap to 00");
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] v;
    bus_start();
    put_byte(AW, a); put_byte(8'h10, a);
    bus_start();
    put_byte(AR, a); chk(a, "R8 repeated start ack", a, 1);
    get_byte(v, 1'b0); chk(v == 8'hA5, "R6 read byte 10", v, 8'hA5);
    get_byte(v, 1'b0); chk(v == 8'h5C, "R6 read after master ack", v, 8'h5C);
    get_byte(v, 1'b1); chk(v == 8'h77, "R6 read byte 12", v, 8'h77);
    chk(sda_pull == 1'b0, "R6 released after nack", sda_pull, 0);
    get_byte(v, 1'b1); chk(v == 8'hFF, "R6 silent after nack", v, 8'hFF);
    bus_stop();
    bus_start();
    put_byte(AR, a);
    get_byte(v, 1'b1); chk(v == 8'h3C, "R8 pointer kept", v, 8'h3C);
    bus_stop();
  endtask

  task automatic t_stop_mid();
    bit a;
    bus_start();
    put_byte(AW, a); put_byte(8'h20, a);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    chk(sda_pull == 1'b0, "R7 released at stop", sda_pull, 0);
    peek(8'h20, 8'h00, "R7 partial byte dropped");
    bus_start();
    m_sda = 1'b1; put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    bus_start();
    put_byte(AW, a); chk(a, "R7 fresh transfer ack", a, 1);
    put_byte(8'h20, a); put_byte(8'h42, a);
    bus_stop();
    peek(8'h20, 8'h42, "R7 write after stop");
  endtask

  initial begin
    wt(5); rst_n = 1'b1; wt(10);
    t_reset();
    t_wrong_addr();
    t_write();
    t_wrap();
    t_read();
    t_stop_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule